// File: doc/BRIEF.md
# UART Transmit Holding Path with Drain Interrupt

This block is the transmit side of a serial port. Software writes bytes into a 16-deep queue through a holding-register strobe. A serializer takes one byte at a time from the queue and sends it as a frame on the line: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The queue-empty interrupt source is edge-based. It requests service only when the queue goes from holding data to holding nothing. An idle queue that has never been filled stays quiet, even after the enable bit is set. To start a transfer, software writes at least one byte. Each later interrupt means the whole queue is free, so one service may write up to 16 bytes.

The serializer is a four-state machine: `SER_IDLE`, `SER_START`, `SER_DATA` and `SER_STOP`.
- `SER_IDLE` → `SER_START` when the queue is not empty. On that edge the head byte is popped into the shift register.
- `SER_START` → `SER_DATA` after 16 baud ticks.
- `SER_DATA` → `SER_DATA` after each 16 ticks, for the first seven data bits.
- `SER_DATA` → `SER_STOP` after 16 ticks of the eighth data bit.
- `SER_STOP` → `SER_IDLE` after 16 ticks.

The queue counts as empty as soon as its last byte is popped. The separate transmitter-idle flag rises only when the stop bit has finished.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, `txd`=1, `irq`=0, `irq_pend`=0, `fifo_empty`=1, `fifo_full`=0, `ovf_flag`=0 and `tx_idle`=1.
- R2: Each frame is a start bit of 0, then eight data bits LSB first, then a stop bit of 1. Every bit lasts exactly 16 `baud_tick` pulses, and the line is 1 between frames.
- R3: The queue holds 16 bytes and sends them in write order. `fifo_full`=1 exactly when 16 bytes are waiting.
- R4: Setting `empty_ie` while the queue is empty and no byte has been written since reset does not raise `irq` or `irq_pend`.
- R5: `irq_pend` becomes 1 on the clock edge after `fifo_empty` rises. `fifo_empty` rises on the edge that pops the last byte into the shift register.
- R6: `irq` = `irq_pend` AND `empty_ie`. Clearing `empty_ie` masks `irq` but keeps `irq_pend`.
- R7: Any pulse on `wr_en` clears `irq_pend` on that edge, including a write that is dropped.
- R8: An `iid_rd` pulse while `irq_pend`=1 clears `irq_pend` on that edge.
- R9: Once serviced, `irq` stays 0 until another byte is written and drains.
- R10: A write while `fifo_full`=1 is discarded and never sent. It sets `ovf_flag`, which stays 1 until reset.
- R11: `tx_idle` rises only after the stop bit of the last frame ends. While `tx_idle`=1, `txd`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Byte to queue |
| empty_ie | input | 1 | Queue-empty interrupt enable |
| iid_rd | input | 1 | Interrupt identification read strobe |
| txd | output | 1 | Serial line, idles high |
| irq | output | 1 | Interrupt request |
| irq_pend | output | 1 | Queue-empty pending condition |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_full | output | 1 | Queue holds 16 bytes |
| ovf_flag | output | 1 | Sticky write-overflow flag |
| tx_idle | output | 1 | Queue empty and serializer idle |

## Verification
A wrong value in the held empty state would show up at `irq_pend` within one cycle of the queue draining. It would appear either as a spurious request on an idle, never-written queue or as a missing request after a drain. A wrong pointer or count inside the queue would show up as a byte that is missing, repeated or out of order in a decoded frame. It would also show as a `fifo_full` flag that rises at the wrong write. A wrong bit counter or tick counter in the serializer would corrupt the next frame. That error is caught when the start, data or stop bit is sampled mid-bit, at most 160 ticks later.

// File: rtl/uth_pkg.sv
package uth_pkg;
    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_START = 2'd1,
        SER_DATA  = 2'd2,
        SER_STOP  = 2'd3
    } ser_state_t;
endpackage

// File: rtl/uth_fifo.sv
module uth_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_req,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          push;

    assign push  = push_req && !full;
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = store[rptr];

    always_ff @(posedge clk) begin
        if (push) store[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
            if (push_req && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/uth_ser.sv
module uth_ser
    import uth_pkg::*;
#(
    parameter int W   = 8,
    parameter int OSR = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         q_empty,
    input  logic [W-1:0] q_head,
    output logic         pop,
    output logic         txd,
    output logic         busy
);
    localparam int TW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    ser_state_t    state, state_nx;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bidx;
    logic [W-1:0]  shreg;
    logic          bit_end;

    assign bit_end = tick && (tcnt == TW'(OSR - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SER_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SER_IDLE:  if (!q_empty) state_nx = SER_START;
            SER_START: if (bit_end)  state_nx = SER_DATA;
            SER_DATA:  if (bit_end && bidx == BW'(W - 1)) state_nx = SER_STOP;
            SER_STOP:  if (bit_end)  state_nx = SER_IDLE;
        endcase
    end

    // datapath counters and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else if (pop) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= q_head;
        end else if (state != SER_IDLE && tick) begin
            tcnt <= bit_end ? '0 : tcnt + 1'b1;
            if (bit_end && state == SER_DATA) begin
                shreg <= shreg >> 1;
                bidx  <= bidx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pop  = 1'b0;
        txd  = 1'b1;
        busy = 1'b1;
        unique case (state)
            SER_IDLE: begin
                busy = 1'b0;
                pop  = !q_empty;
            end
            SER_START: txd = 1'b0;
            SER_DATA:  txd = shreg[0];
            SER_STOP:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uth_drain_irq.sv
module uth_drain_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic q_empty,
    input  logic wr_strobe,
    input  logic id_read,
    input  logic enable,
    output logic pend,
    output logic req
);
    logic empty_d;
    logic set_ev, clr_ev;

    assign set_ev = q_empty && !empty_d;
    assign clr_ev = wr_strobe || (id_read && pend);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_d <= 1'b1;
            pend    <= 1'b0;
        end else begin
            empty_d <= q_empty;
            if (set_ev)      pend <= 1'b1;
            else if (clr_ev) pend <= 1'b0;
        end
    end

    assign req = pend && enable;
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int OSR   = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         baud_tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         empty_ie,
    input  logic         iid_rd,
    output logic         txd,
    output logic         irq,
    output logic         irq_pend,
    output logic         fifo_empty,
    output logic         fifo_full,
    output logic         ovf_flag,
    output logic         tx_idle
);
    logic         pop, busy;
    logic [W-1:0] head;

    uth_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(wr_en), .push_data(wr_data),
        .pop(pop), .head(head), .empty(fifo_empty), .full(fifo_full),
        .ovf(ovf_flag)
    );

    uth_ser #(.W(W), .OSR(OSR)) u_ser (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .q_empty(fifo_empty),
        .q_head(head), .pop(pop), .txd(txd), .busy(busy)
    );

    uth_drain_irq u_irq (
        .clk(clk), .rst_n(rst_n), .q_empty(fifo_empty), .wr_strobe(wr_en),
        .id_read(iid_rd), .enable(empty_ie), .pend(irq_pend), .req(irq)
    );

    assign tx_idle = fifo_empty && !busy;
endmodule

// File: rtl/uart_tx_hold_chk.sv
module uart_tx_hold_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic iid_rd,
    input logic empty_ie,
    input logic txd,
    input logic irq,
    input logic irq_pend,
    input logic fifo_empty,
    input logic fifo_full,
    input logic ovf_flag,
    input logic tx_idle
);
    // R4
    pend_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> fifo_empty);

    // R5
    drain_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_empty) |=> irq_pend);

    // R6
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_ie |-> !irq);

    // R6
    unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && empty_ie) |-> irq);

    // R7
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && irq_pend) |=> !irq_pend);

    // R8
    id_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd && irq_pend) |=> !irq_pend);

    // R10
    ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_full) |=> ovf_flag);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R11
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);
endmodule

bind uart_tx_hold uart_tx_hold_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .iid_rd(iid_rd),
    .empty_ie(empty_ie), .txd(txd), .irq(irq), .irq_pend(irq_pend),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .ovf_flag(ovf_flag),
    .tx_idle(tx_idle)
);

// File: tb/uart_tx_hold_test.sv
module uart_tx_hold_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       empty_ie = 1'b0;
    logic       iid_rd = 1'b0;
    logic txd, irq, irq_pend, fifo_empty, fifo_full, ovf_flag, tx_idle;

    int vectors = 0;
    int miscompares = 0;
    int frames_rx = 0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    uart_tx_hold uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .empty_ie(empty_ie), .iid_rd(iid_rd), .txd(txd),
        .irq(irq), .irq_pend(irq_pend), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .ovf_flag(ovf_flag), .tx_idle(tx_idle)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // driver: push the byte into the scoreboard when R3/R10 say it is accepted
    task automatic write_byte(input logic [7:0] d, input bit accept);
        wr_en = 1'b1;
        wr_data = d;
        if (accept) exp_q.push_back(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit && !tx_idle; i++) @(negedge clk);
    endtask

    // baud tick every other clock
    initial forever begin
        @(posedge clk); #1;
        baud_tick = ~baud_tick;
    end

    // monitor: decode frames mid-bit, compare against scoreboard
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !txd) begin
                int n;
                logic [7:0] got;
                n = baud_tick ? 1 : 0;
                while (n < 8) begin @(negedge clk); if (baud_tick) n++; end
                check("R2 start bit", txd, 1'b0);
                for (int j = 0; j < 8; j++) begin
                    while (n < 24 + 16 * j) begin @(negedge clk); if (baud_tick) n++; end
                    got[j] = txd;
                end
                while (n < 152) begin @(negedge clk); if (baud_tick) n++; end
                check("R2 stop bit", txd, 1'b1);
                frames_rx++;
                if (exp_q.size() == 0) check("R10 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
                else check("R3 R2 frame data", got, exp_q.pop_front());
            end
            prev = txd;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit seen;
        repeat (5) @(posedge clk); #1;
        rst_n = 1'b1;

        @(negedge clk);
        check("R1 txd", txd, 1);
        check("R1 irq", irq, 0);
        check("R1 irq_pend", irq_pend, 0);
        check("R1 fifo_empty", fifo_empty, 1);
        check("R1 fifo_full", fifo_full, 0);
        check("R1 ovf_flag", ovf_flag, 0);
        check("R1 tx_idle", tx_idle, 1);

        // R4: enable on a never-written empty queue
        @(posedge clk); #1 empty_ie = 1'b1;
        seen = 0;
        repeat (60) begin @(negedge clk); if (irq || irq_pend) seen = 1; end
        check("R4 no request when idle", seen, 0);

        // R5 / R11: first byte drains
        @(posedge clk); #1;
        write_byte(8'hA5, 1);
        @(negedge clk);
        check("R5 queue holds byte", fifo_empty, 0);
        for (int i = 0; i < 10 && !fifo_empty; i++) @(negedge clk);
        check("R5 empty on pop", fifo_empty, 1);
        check("R11 still sending", tx_idle, 0);
        check("R5 pend not yet", irq_pend, 0);
        @(negedge clk);
        check("R5 irq one edge later", irq, 1);
        wait_idle(2000);
        check("R11 idle after stop", tx_idle, 1);
        check("R11 frame complete", frames_rx, 1);

        // R6: masking
        @(posedge clk); #1 empty_ie = 1'b0;
        @(negedge clk);
        check("R6 masked irq", irq, 0);
        check("R6 pend kept", irq_pend, 1);
        @(posedge clk); #1 empty_ie = 1'b1;
        @(negedge clk);
        check("R6 unmasked irq", irq, 1);

        // R8: identification read clears
        @(posedge clk); #1 iid_rd = 1'b1;
        @(posedge clk); #1 iid_rd = 1'b0;
        @(negedge clk);
        check("R8 pend cleared", irq_pend, 0);

        // R9: stays quiet
        seen = 0;
        repeat (400) begin @(negedge clk); if (irq) seen = 1; end
        check("R9 no repeat", seen, 0);

        // R9 again after new byte drains, then R7 write clears
        @(posedge clk); #1;
        write_byte(8'h3C, 1);
        for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
        check("R9 re-raised after drain", irq, 1);
        @(posedge clk); #1;
        write_byte(8'h81, 1);
        @(negedge clk);
        check("R7 write clears pend", irq_pend, 0);
        check("R7 irq low", irq, 0);
        wait_idle(2000);
        @(negedge clk);
        check("R5 second drain raises", irq, 1);

        // R3 / R10: burst of 17 (first is popped at once), then overflow
        @(posedge clk); #1;
        for (int i = 0; i < 17; i++) write_byte(8'(8'h10 + i * 7), 1);
        @(negedge clk);
        check("R3 full at 16", fifo_full, 1);
        check("R10 no ovf yet", ovf_flag, 0);
        @(posedge clk); #1;
        write_byte(8'hEE, 0);
        @(negedge clk);
        check("R10 ovf set", ovf_flag, 1);
        check("R10 still full", fifo_full, 1);
        wait_idle(20000);
        repeat (4) @(negedge clk);
        check("R3 all frames sent", frames_rx, 20);
        check("R3 scoreboard drained", exp_q.size(), 0);
        check("R10 ovf sticky", ovf_flag, 1);
        check("R5 burst drain raises", irq, 1);

        summary();
    end
endmodule